// File: doc/BRIEF.md
# Sensor Startup Phase Message Sequencer

This block decides which message a sensor's serial reporting path sends next, and when it sends it. After reset it steps through five phases in a fixed order. First comes an initialization period, then the identity and user data, then a self-test report, then an optional auto-zero period, and finally a steady stream of acceleration samples. Each message is handed to a downstream line encoder as a 3-bit type tag plus an 11-bit payload, together with a one-cycle send strobe. The line coding and the signalling on the wire belong to that encoder, not to this block.

Message pacing has two modes. In the free-running mode, an internal timer counts microsecond ticks and opens one message slot every 228 ticks. In the bus-sharing mode the timer is ignored, and each valid synchronization pulse opens exactly one slot. This lets two sensors take turns on one bus. A slot that has opened is held until the encoder reports that it is ready. Further slots that arrive while one is already held are absorbed, not queued.

The self-test result is sampled when the status message is sent. A failure sets a sticky error bit. That bit is reported in the status message and in every acceleration message after it, and the sequence still carries on to the normal phase.

Top module: `sensor_phase_seq`

## Requirements
- R1: While reset is held and right after it is released, `phase` reads 1 (initialization) and `msg_valid` is 0.
- R2: The initialization phase consumes 16 message slots without sending anything. After the 16th slot `phase` becomes 2.
- R3: Phase 2 sends seven messages in this order, each carrying its index 0..6 in payload bits 10:8. Indices 0..3 carry serial bytes 7:0, 15:8, 23:16 and 31:24, and index 4 carries the manufacturer/revision byte; all five use tag 1 (identity). Index 5 carries the user byte and index 6 carries the ninth user bit in payload bit 0; both use tag 2 (user). The byte sits in payload bits 7:0.
- R4: Phase 3 sends one status message with tag 3. Payload bit 0 is the sticky error bit, which includes the `st_fail` level sampled as the message is sent. Bit 1 is the auto-zero enable, and all other bits are 0.
- R5: After the status message, `phase` becomes 4 if `cfg_autozero_en` is 1 and 5 otherwise. Phase 4 ends and `phase` becomes 5 in the cycle after `az_done` is seen high.
- R6: In phases 4 and 5 every slot sends an acceleration message with tag 4. Payload bits 9:0 hold `acc_sample` and bit 10 holds the sticky error bit.
- R7: With `cfg_sync_mode` at 0, a message slot opens once every 228 `us_tick` pulses and `sync_pulse` has no effect. With a tick on every cycle, messages are exactly 228 cycles apart.
- R8: With `cfg_sync_mode` at 1, `us_tick` has no effect and each `sync_pulse` releases exactly one message within five cycles.
- R9: No message is sent while `enc_ready` is 0. A held slot is sent once `enc_ready` returns to 1, and extra slots that arrive while one is held are dropped.
- R10: Once set, the error bit stays set in every later acceleration message, even after `st_fail` falls. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| sync_pulse | input | 1 | One-cycle strobe per valid synchronization pulse |
| cfg_user | input | 8 | User-programmed data byte |
| cfg_ud8 | input | 1 | Ninth user bit |
| cfg_sync_mode | input | 1 | 1 = slots released by sync pulses |
| cfg_autozero_en | input | 1 | 1 = run the auto-zero phase |
| id_serial | input | 32 | Factory serial number |
| id_mfg_rev | input | 8 | Revision (bits 5:3) and manufacturer ID (bits 2:0) |
| st_fail | input | 1 | Self-test failure flag |
| az_done | input | 1 | Auto-zero finished flag |
| acc_sample | input | 10 | Latest acceleration sample |
| enc_ready | input | 1 | Downstream encoder can take a message |
| msg_valid | output | 1 | Send strobe, one cycle per message |
| msg_tag | output | 3 | Message type tag |
| msg_data | output | 11 | Message payload |
| phase | output | 3 | Current phase, 1 to 5 |

## Verification
The checker watches four properties on every cycle. Nothing is sent during initialization. Every message follows a cycle in which the encoder was ready. Each message type appears only in the phases that own it, and phases only step forward, with the single allowed skip from 3 to 5. The checker also verifies that the error bit never drops out of acceleration messages once it has been reported. The remaining behaviours depend on configuration and on how slots are delivered, so only the bench scenarios can show them. These are the exact order and contents of the identity messages, the 228-tick spacing, the fact that sync pulses are ignored in free-running mode and ticks are ignored in bus-sharing mode, and the absorbing of surplus slots while the encoder is stalled.

// File: rtl/sps_pkg.sv
package sps_pkg;

    localparam int ACC_W     = 10;
    localparam int PAY_W     = ACC_W + 1;
    localparam int SN_BYTES  = 4;
    localparam int DEV_MSGS  = SN_BYTES + 3;
    localparam int DIDX_W    = 3;

    typedef enum logic [2:0] {
        PH_INIT     = 3'd1,
        PH_DEVDATA  = 3'd2,
        PH_SELFTEST = 3'd3,
        PH_AUTOZERO = 3'd4,
        PH_NORMAL   = 3'd5
    } phase_e;

    typedef enum logic [2:0] {
        TAG_IDENT  = 3'd1,
        TAG_USER   = 3'd2,
        TAG_STATUS = 3'd3,
        TAG_ACCEL  = 3'd4
    } tag_e;

    typedef struct packed {
        tag_e             tag;
        logic [PAY_W-1:0] data;
    } msg_t;

endpackage

// File: rtl/sps_slot_pacer.sv
module sps_slot_pacer #(
    parameter int PERIOD_US = 228
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic us_tick,
    input  logic sync_pulse,
    output logic slot
);
    localparam int CW = (PERIOD_US > 1) ? $clog2(PERIOD_US) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          slot;
    } pacer_t;

    pacer_t q, d;

    always_comb begin
        d      = q;
        d.slot = 1'b0;
        if (sync_mode) begin
            d.cnt  = '0;
            d.slot = sync_pulse;
        end else if (us_tick) begin
            if (q.cnt == CW'(PERIOD_US - 1)) begin
                d.cnt  = '0;
                d.slot = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign slot = q.slot;
endmodule

// File: rtl/sps_payload_mux.sv
module sps_payload_mux
    import sps_pkg::*;
(
    input  phase_e                  cur_phase,
    input  logic [DIDX_W-1:0]       idx,
    input  logic [8*SN_BYTES-1:0]   serial,
    input  logic [7:0]              mfg_rev,
    input  logic [7:0]              user_byte,
    input  logic                    ud8,
    input  logic                    az_en,
    input  logic                    err_flag,
    input  logic [ACC_W-1:0]        acc,
    output msg_t                    msg
);
    localparam int SEL_W = $clog2(SN_BYTES);

    logic [7:0] sn_byte [SN_BYTES];

    for (genvar g = 0; g < SN_BYTES; g++) begin : g_snb
        assign sn_byte[g] = serial[8*g +: 8];
    end

    always_comb begin
        msg.tag  = TAG_ACCEL;
        msg.data = {err_flag, acc};
        case (cur_phase)
            PH_DEVDATA: begin
                if (int'(idx) < SN_BYTES) begin
                    msg.tag  = TAG_IDENT;
                    msg.data = {idx, sn_byte[idx[SEL_W-1:0]]};
                end else if (int'(idx) == SN_BYTES) begin
                    msg.tag  = TAG_IDENT;
                    msg.data = {idx, mfg_rev};
                end else if (int'(idx) == SN_BYTES + 1) begin
                    msg.tag  = TAG_USER;
                    msg.data = {idx, user_byte};
                end else begin
                    msg.tag  = TAG_USER;
                    msg.data = {idx, 7'd0, ud8};
                end
            end
            PH_SELFTEST: begin
                msg.tag  = TAG_STATUS;
                msg.data = PAY_W'({az_en, err_flag});
            end
            default: begin
                msg.tag  = TAG_ACCEL;
                msg.data = {err_flag, acc};
            end
        endcase
    end
endmodule

// File: rtl/sensor_phase_seq.sv
module sensor_phase_seq
    import sps_pkg::*;
#(
    parameter int PERIOD_US  = 228,
    parameter int INIT_SLOTS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  us_tick,
    input  logic                  sync_pulse,
    input  logic [7:0]            cfg_user,
    input  logic                  cfg_ud8,
    input  logic                  cfg_sync_mode,
    input  logic                  cfg_autozero_en,
    input  logic [8*SN_BYTES-1:0] id_serial,
    input  logic [7:0]            id_mfg_rev,
    input  logic                  st_fail,
    input  logic                  az_done,
    input  logic [ACC_W-1:0]      acc_sample,
    input  logic                  enc_ready,
    output logic                  msg_valid,
    output logic [2:0]            msg_tag,
    output logic [PAY_W-1:0]      msg_data,
    output logic [2:0]            phase
);
    localparam int CNT_MAX = (INIT_SLOTS > DEV_MSGS) ? INIT_SLOTS : DEV_MSGS;
    localparam int IDX_W   = $clog2(CNT_MAX);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
        logic             pending;
        logic             err;
        logic             valid;
        msg_t             msg;
    } state_t;

    localparam state_t ST_RST = '{
        phase:   PH_INIT,
        idx:     '0,
        pending: 1'b0,
        err:     1'b0,
        valid:   1'b0,
        msg:     '{tag: TAG_IDENT, data: '0}
    };

    state_t q, d;
    logic   slot;
    logic   fire;
    logic   err_flag;
    msg_t   cand;

    sps_slot_pacer #(.PERIOD_US(PERIOD_US)) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_mode  (cfg_sync_mode),
        .us_tick    (us_tick),
        .sync_pulse (sync_pulse),
        .slot       (slot)
    );

    assign err_flag = (q.phase == PH_SELFTEST) ? (q.err | st_fail) : q.err;

    sps_payload_mux u_mux (
        .cur_phase (q.phase),
        .idx       (q.idx[DIDX_W-1:0]),
        .serial    (id_serial),
        .mfg_rev   (id_mfg_rev),
        .user_byte (cfg_user),
        .ud8       (cfg_ud8),
        .az_en     (cfg_autozero_en),
        .err_flag  (err_flag),
        .acc       (acc_sample),
        .msg       (cand)
    );

    assign fire = q.pending && enc_ready;

    always_comb begin
        d         = q;
        d.valid   = 1'b0;
        d.pending = q.pending | slot;
        if (fire && q.phase != PH_INIT) begin
            d.valid   = 1'b1;
            d.msg     = cand;
            d.pending = slot;
        end
        case (q.phase)
            PH_INIT: begin
                if (q.pending) begin
                    d.pending = slot;
                    if (q.idx == IDX_W'(INIT_SLOTS - 1)) begin
                        d.phase = PH_DEVDATA;
                        d.idx   = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            PH_DEVDATA: begin
                if (fire) begin
                    if (q.idx == IDX_W'(DEV_MSGS - 1)) begin
                        d.phase = PH_SELFTEST;
                        d.idx   = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            PH_SELFTEST: begin
                if (fire) begin
                    d.err   = q.err | st_fail;
                    d.phase = cfg_autozero_en ? PH_AUTOZERO : PH_NORMAL;
                end
            end
            PH_AUTOZERO: begin
                if (az_done) d.phase = PH_NORMAL;
            end
            PH_NORMAL: ;
            default: d.phase = PH_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= ST_RST;
        else        q <= d;
    end

    assign msg_valid = q.valid;
    assign msg_tag   = q.msg.tag;
    assign msg_data  = q.msg.data;
    assign phase     = q.phase;
endmodule

// File: rtl/sps_seq_chk.sv
module sps_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        enc_ready,
    input logic        msg_valid,
    input logic [2:0]  msg_tag,
    input logic [10:0] msg_data,
    input logic [2:0]  phase
);
    logic seen_err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_err <= 1'b0;
        else if (msg_valid && ((msg_tag == 3'd3 && msg_data[0]) ||
                               (msg_tag == 3'd4 && msg_data[10])))
            seen_err <= 1'b1;
    end

    a_r2_silent_init: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1) |-> !msg_valid);

    a_r9_ready_gate: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> $past(enc_ready));

    a_r3_ident_in_phase2: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_tag == 3'd1 || msg_tag == 3'd2)) |-> $past(phase) == 3'd2);

    a_r4_status_in_phase3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_tag == 3'd3) |-> $past(phase) == 3'd3);

    a_r6_accel_late: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_tag == 3'd4) |-> $past(phase) >= 3'd4);

    a_r5_phase_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != $past(phase)) |->
            (phase == $past(phase) + 3'd1) || ($past(phase) == 3'd3 && phase == 3'd5));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_tag == 3'd4 && seen_err) |-> msg_data[10]);
endmodule

bind sensor_phase_seq sps_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enc_ready (enc_ready),
    .msg_valid (msg_valid),
    .msg_tag   (msg_tag),
    .msg_data  (msg_data),
    .phase     (phase)
);

// File: tb/tb_sensor_phase_seq.sv
module tb_sensor_phase_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_on = 1'b0;
    logic        noise_on = 1'b0;
    logic        noise_pulse = 1'b0;
    logic        manual_pulse = 1'b0;
    logic        us_tick, sync_pulse;
    logic [7:0]  cfg_user = '0;
    logic        cfg_ud8 = 1'b0, cfg_sync_mode = 1'b0, cfg_autozero_en = 1'b0;
    logic [31:0] id_serial = '0;
    logic [7:0]  id_mfg_rev = '0;
    logic        st_fail = 1'b0, az_done = 1'b0, enc_ready = 1'b1;
    logic [9:0]  acc_sample = '0;
    logic        msg_valid;
    logic [2:0]  msg_tag;
    logic [10:0] msg_data;
    logic [2:0]  phase;

    int total = 0, fails = 0;
    int cyc_cnt = 0;
    int nmsg = 0;
    int r0 = 0;
    logic [13:0] log_msg  [64];
    int          log_time [64];

    assign us_tick    = tick_on;
    assign sync_pulse = manual_pulse | noise_pulse;

    always #5 clk = ~clk;

    sensor_phase_seq dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .sync_pulse(sync_pulse),
        .cfg_user(cfg_user), .cfg_ud8(cfg_ud8), .cfg_sync_mode(cfg_sync_mode),
        .cfg_autozero_en(cfg_autozero_en), .id_serial(id_serial), .id_mfg_rev(id_mfg_rev),
        .st_fail(st_fail), .az_done(az_done), .acc_sample(acc_sample), .enc_ready(enc_ready),
        .msg_valid(msg_valid), .msg_tag(msg_tag), .msg_data(msg_data), .phase(phase)
    );

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    always @(negedge clk) begin
        noise_pulse <= noise_on && ($urandom % 7 == 0);
        if (msg_valid && nmsg < 64) begin
            log_msg[nmsg]  = {msg_tag, msg_data};
            log_time[nmsg] = cyc_cnt;
            nmsg = nmsg + 1;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [13:0] exp_dev(int i);
        case (i)
            0, 1, 2, 3: return {3'd1, 3'(i), id_serial[8*i +: 8]};
            4:          return {3'd1, 3'd4, id_mfg_rev};
            5:          return {3'd2, 3'd5, cfg_user};
            default:    return {3'd2, 3'd6, 7'd0, cfg_ud8};
        endcase
    endfunction

    task automatic randomize_ids();
        id_serial  = $urandom;
        id_mfg_rev = 8'($urandom);
        cfg_user   = 8'($urandom);
        cfg_ud8    = 1'($urandom);
        acc_sample = 10'($urandom);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cyc(3);
        nmsg  = 0;
        rst_n = 1'b1;
        r0    = cyc_cnt;
        chk("R1", 32'(phase), 32'd1, "phase after reset");
        chk("R1", 32'(msg_valid), 32'd0, "msg_valid after reset");
    endtask

    task automatic pulse();
        manual_pulse = 1'b1;
        cyc(1);
        manual_pulse = 1'b0;
        cyc(5);
    endtask

    task automatic run_async(logic fail);
        randomize_ids();
        cfg_sync_mode = 1'b0; cfg_autozero_en = 1'b0;
        st_fail = fail; az_done = 1'b0; enc_ready = 1'b1;
        tick_on = 1'b1; noise_on = 1'b1;
        do_reset();
        for (int w = 0; w < 20000 && nmsg < 10; w++) cyc(1);
        chk("R7", 32'(nmsg), 32'd10, "message count reached");
        chk("R2", 32'((log_time[0] - r0) > 16 * 228), 32'd1, "no message during init slots");
        for (int i = 0; i < 7; i++) chk("R3", 32'(log_msg[i]), 32'(exp_dev(i)), "async device data");
        chk("R4", 32'(log_msg[7]), 32'({3'd3, 11'({1'b0, fail})}), "async status");
        for (int i = 8; i < 10; i++)
            chk("R6", 32'(log_msg[i]), 32'({3'd4, fail, acc_sample}), "async accel");
        for (int i = 0; i < 9; i++)
            chk("R7", 32'(log_time[i+1] - log_time[i]), 32'd228, "slot spacing, sync ignored");
        chk("R5", 32'(phase), 32'd5, "no auto-zero goes to normal");
        noise_on = 1'b0;
    endtask

    task automatic run_sync(logic az, logic fail);
        logic [9:0] a;
        randomize_ids();
        cfg_sync_mode = 1'b1; cfg_autozero_en = az;
        st_fail = fail; az_done = 1'b0; enc_ready = 1'b1;
        tick_on = 1'b1; noise_on = 1'b0;
        do_reset();
        cyc(600);
        chk("R8", 32'(nmsg), 32'd0, "ticks ignored in sync mode");
        chk("R8", 32'(phase), 32'd1, "phase held without pulses");
        repeat (16) pulse();
        chk("R2", 32'(nmsg), 32'd0, "init slots silent");
        chk("R2", 32'(phase), 32'd2, "phase 2 after 16 slots");
        for (int i = 0; i < 7; i++) begin
            pulse();
            chk("R8", 32'(nmsg), 32'(i + 1), "one message per pulse");
            chk("R3", 32'(log_msg[i]), 32'(exp_dev(i)), "sync device data");
        end
        pulse();
        chk("R4", 32'(log_msg[7]), 32'({3'd3, 11'({az, fail})}), "sync status");
        chk("R5", 32'(phase), az ? 32'd4 : 32'd5, "phase after status");
        for (int k = 0; k < 2; k++) begin
            a = 10'($urandom);
            acc_sample = a;
            pulse();
            chk("R6", 32'(log_msg[8+k]), 32'({3'd4, fail, a}), "accel payload");
        end
        if (az) begin
            az_done = 1'b1;
            cyc(3);
            chk("R5", 32'(phase), 32'd5, "auto-zero done ends phase 4");
            az_done = 1'b0;
        end
        st_fail = 1'b0;
        a = 10'($urandom);
        acc_sample = a;
        pulse();
        chk("R10", 32'(log_msg[10]), 32'({3'd4, fail, a}), "error bit sticky");
    endtask

    task automatic run_ready();
        int n;
        n = nmsg;
        enc_ready = 1'b0;
        repeat (3) pulse();
        cyc(10);
        chk("R9", 32'(nmsg), 32'(n), "nothing sent while not ready");
        enc_ready = 1'b1;
        cyc(10);
        chk("R9", 32'(nmsg), 32'(n + 1), "one held message sent");
        chk("R9", 32'(log_msg[n][13:11]), 32'd4, "held message is accel");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL R1 watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int unsigned s;
        s = $urandom(32'd2024);
        run_async(1'($urandom));
        run_sync(1'b1, 1'b1);
        run_sync(1'b0, 1'b0);
        run_sync(1'($urandom), 1'($urandom));
        run_ready();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule